// File: doc/BRIEF.md
# Cluster Performance Counter Unit

This block counts activity inside a processor cluster. It holds a parameterised number of 32-bit event counters and one 64-bit cycle counter, all behind a word-addressed read/write register port. Each event counter picks its source with an 8-bit event code. The code can select a free-running tick, one bit of a per-cycle event pulse vector, or, on odd-numbered counters, a link to the wrap of the even counter below it. That link lets two 32-bit counters act as one 64-bit count.

All per-counter bitmaps use bit n for event counter n and bit 31 for the cycle counter. A counter that wraps from all-ones to zero sets its bit in a shared overflow status word. Reading that word returns it and clears the returned bits in the same access. A single interrupt line is raised while any overflow bit has its interrupt enable set. Software can preload any counter, stop all counting through a global run bit, and zero the event counters or the cycle counter through command bits in the control word.

Each event counter decodes its event code into one of four source kinds: SRC_OFF (never counts), SRC_TICK (counts every enabled cycle), SRC_PIN (follows one bit of the event pulse vector) and SRC_LINK (counts the lower neighbour's wrap). The block has no sequencing state beyond this per-cycle decode.

Top module: `clu_pmu`

## Requirements
- R1: Control word at address 0x00: bit 0 is the run bit (read/write). Bits 1 and 2 are write-only commands that read as 0. Bits [15:11] read the number of event counters NUM_EVT. Bits [23:16] read ID_CODE and bits [31:24] read IMPL_CODE. Both codes are read-only.
- R2: A counter advances by exactly one in a cycle only when the run bit is set, its bit in the enable bitmap (address 0x01) is set, and its source fires. Otherwise it holds its value.
- R3: Event code 0x11 counts every cycle. A code below 64 whose bit is set in CODE_MASK counts the cycles in which evt_i[code] is high. Any other code never counts. Address 0x04 reads CODE_MASK[31:0] and 0x05 reads CODE_MASK[63:32]. Event types are written at 0x60+n, bits [7:0]. Address 0x7F reads 0x11 and ignores writes.
- R4: An odd counter with code 0x1e advances in the same cycle that the counter one below it wraps. An even counter with code 0x1e never advances.
- R5: Event counters wrap at 32 bits and the cycle counter at 64 bits. Counter n reads and writes at 0x40+n. The cycle counter's low half is at 0x06 and 0x5F, and its high half at 0x07.
- R6: A wrap sets bit n (or bit 31 for the cycle counter) of the overflow status at 0x03. A read of 0x03 returns the status and clears the returned bits. A wrap in the reading cycle remains set. Writes to 0x03 are ignored.
- R7: irq_o is high exactly while some overflow bit has its bit set in the interrupt enable bitmap (address 0x02).
- R8: Writing the control word with bit 1 set zeroes all event counters. Writing it with bit 2 set zeroes the cycle counter. A reset command takes priority over a preload and an increment in the same cycle.
- R9: A write to a counter loads the written value. It takes priority over an increment in the same cycle.
- R10: Counter indices from NUM_EVT to 30 are not implemented. Their value, type and bitmap bits read as 0, and writes to them are ignored.
- R11: A read request returns its data on rdata_o with rvalid_o high in the next cycle. rdata_o is 0 in cycles without a read response, and a read sees the state from before any write in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| evt_i | input | 64 | Per-cycle event pulses indexed by event code |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench targets three same-cycle collisions:
- A counter wrap during the read of the overflow status. A design that cleared unconditionally would lose that overflow and drop the interrupt.
- A preload against an increment. A design with the priority inverted would read one above the written value.
- A reset command against a running counter. A design with the priority inverted would not return to zero.

The chained pair is driven across the wrap of its lower counter. A design that took the link a cycle late, or let an even counter take it, would show a high half off by one.

The cycle counter is preloaded near 2^64 so that a carry across its two halves lands on bit 31. Unimplemented slots are written to confirm they stay at zero and never leak into the bitmaps.

// File: rtl/clu_pmu_pkg.sv
package clu_pmu_pkg;

    localparam int         CNT_W      = 32;
    localparam int         CYC_W      = 64;
    localparam int         EVT_CODES  = 64;
    localparam int         CODE_W     = $clog2(EVT_CODES);
    localparam int         CYC_SLOT   = 31;

    localparam logic [7:0] CODE_TICK  = 8'h11;
    localparam logic [7:0] CODE_LINK  = 8'h1e;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_EN     = 8'h01;
    localparam logic [7:0] OFS_IE     = 8'h02;
    localparam logic [7:0] OFS_OVF    = 8'h03;
    localparam logic [7:0] OFS_EIDLO  = 8'h04;
    localparam logic [7:0] OFS_EIDHI  = 8'h05;
    localparam logic [7:0] OFS_CYCLO  = 8'h06;
    localparam logic [7:0] OFS_CYCHI  = 8'h07;
    localparam logic [2:0] PAGE_VALUE = 3'b010;
    localparam logic [2:0] PAGE_TYPE  = 3'b011;

    typedef enum logic [1:0] {
        SRC_OFF,
        SRC_TICK,
        SRC_PIN,
        SRC_LINK
    } src_kind_e;

    typedef struct packed {
        logic ctrl;
        logic en;
        logic ie;
        logic ovf_rd;
        logic cyc_lo;
        logic cyc_hi;
    } port_strobe_t;

endpackage

// File: rtl/clu_pmu_evcnt.sv
module clu_pmu_evcnt
    import clu_pmu_pkg::*;
#(
    parameter int                    IDX       = 0,
    parameter logic [EVT_CODES-1:0]  CODE_MASK = '0
)(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 count_en_i,
    input  logic                 clr_i,
    input  logic                 val_we_i,
    input  logic [CNT_W-1:0]     val_wdata_i,
    input  logic                 type_we_i,
    input  logic [7:0]           type_wdata_i,
    input  logic [EVT_CODES-1:0] evt_i,
    input  logic                 link_i,
    output logic [CNT_W-1:0]     value_o,
    output logic [7:0]           type_o,
    output logic                 wrap_o
);

    localparam bit ODD = (IDX % 2) == 1;

    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       type_q;
    src_kind_e        kind;
    logic             hit;
    logic             inc;

    always_comb begin
        if (type_q == CODE_TICK) begin
            kind = SRC_TICK;
        end else if (type_q == CODE_LINK) begin
            kind = ODD ? SRC_LINK : SRC_OFF;
        end else if ((type_q < 8'(EVT_CODES)) && CODE_MASK[type_q[CODE_W-1:0]]) begin
            kind = SRC_PIN;
        end else begin
            kind = SRC_OFF;
        end
    end

    always_comb begin
        unique case (kind)
            SRC_TICK: hit = 1'b1;
            SRC_PIN:  hit = evt_i[type_q[CODE_W-1:0]];
            SRC_LINK: hit = link_i;
            default:  hit = 1'b0;
        endcase
    end

    assign inc    = count_en_i & hit & ~val_we_i & ~clr_i;
    assign wrap_o = inc & (&cnt_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            type_q <= '0;
        end else begin
            if (clr_i) begin
                cnt_q <= '0;
            end else if (val_we_i) begin
                cnt_q <= val_wdata_i;
            end else if (inc) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (type_we_i) begin
                type_q <= type_wdata_i;
            end
        end
    end

    assign value_o = cnt_q;
    assign type_o  = type_q;

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!val_we_i && !clr_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R2
    AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!count_en_i && !val_we_i && !clr_i) |=> $stable(cnt_q)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (cnt_q == '0)); // R5
    AST_LINK_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ODD && type_q == CODE_LINK && !val_we_i && !clr_i) |=> $stable(cnt_q)); // R4
    AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/clu_pmu_cyccnt.sv
module clu_pmu_cyccnt
    import clu_pmu_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             count_en_i,
    input  logic             clr_i,
    input  logic             lo_we_i,
    input  logic             hi_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CYC_W-1:0] value_o,
    output logic             wrap_o
);

    logic [CYC_W-1:0] cyc_q;
    logic             inc;

    assign inc    = count_en_i & ~clr_i & ~lo_we_i & ~hi_we_i;
    assign wrap_o = inc & (&cyc_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cyc_q <= '0;
        end else if (clr_i) begin
            cyc_q <= '0;
        end else if (lo_we_i || hi_we_i) begin
            if (lo_we_i) cyc_q[CNT_W-1:0]     <= wdata_i;
            if (hi_we_i) cyc_q[CYC_W-1:CNT_W] <= wdata_i;
        end else if (inc) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    assign value_o = cyc_q;

    AST_CYC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lo_we_i && !hi_we_i && !clr_i) |=> (cyc_q == $past(cyc_q) || cyc_q == $past(cyc_q) + 1'b1)); // R2
    AST_CYC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cyc_q == '0)); // R8
    AST_CYC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (cyc_q == '0)); // R5

endmodule

// File: rtl/clu_pmu_regport.sv
module clu_pmu_regport
    import clu_pmu_pkg::*;
#(
    parameter int                   NUM       = 6,
    parameter logic [7:0]           ID_CODE   = 8'h5A,
    parameter logic [7:0]           IMPL_CODE = 8'hC3,
    parameter logic [EVT_CODES-1:0] CODE_MASK = '0
)(
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     req_i,
    input  logic                     we_i,
    input  logic [7:0]               addr_i,
    input  logic                     run_i,
    input  logic [31:0]              en_i,
    input  logic [31:0]              ie_i,
    input  logic [31:0]              ovf_i,
    input  logic [CYC_W-1:0]         cyc_i,
    input  logic [NUM-1:0][CNT_W-1:0] cnt_i,
    input  logic [NUM-1:0][7:0]      type_i,
    output port_strobe_t             stb_o,
    output logic [NUM-1:0]           cnt_we_o,
    output logic [NUM-1:0]           type_we_o,
    output logic                     rvalid_o,
    output logic [31:0]              rdata_o
);

    logic        wr;
    logic        rd;
    logic [2:0]  page;
    logic [4:0]  slot;
    logic [31:0] rd_word;
    logic        rvalid_q;
    logic [31:0] rdata_q;

    assign wr   = req_i & we_i;
    assign rd   = req_i & ~we_i;
    assign page = addr_i[7:5];
    assign slot = addr_i[4:0];

    always_comb begin
        stb_o.ctrl   = wr && (addr_i == OFS_CTRL);
        stb_o.en     = wr && (addr_i == OFS_EN);
        stb_o.ie     = wr && (addr_i == OFS_IE);
        stb_o.ovf_rd = rd && (addr_i == OFS_OVF);
        stb_o.cyc_lo = wr && ((addr_i == OFS_CYCLO) ||
                              (page == PAGE_VALUE && slot == 5'(CYC_SLOT)));
        stb_o.cyc_hi = wr && (addr_i == OFS_CYCHI);
    end

    for (genvar g = 0; g < NUM; g++) begin : g_dec
        assign cnt_we_o[g]  = wr && (page == PAGE_VALUE) && (slot == 5'(g));
        assign type_we_o[g] = wr && (page == PAGE_TYPE)  && (slot == 5'(g));
    end

    always_comb begin
        rd_word = '0;
        case (addr_i)
            OFS_CTRL:  rd_word = {IMPL_CODE, ID_CODE, 5'(NUM), 10'd0, run_i};
            OFS_EN:    rd_word = en_i;
            OFS_IE:    rd_word = ie_i;
            OFS_OVF:   rd_word = ovf_i;
            OFS_EIDLO: rd_word = CODE_MASK[31:0];
            OFS_EIDHI: rd_word = CODE_MASK[63:32];
            OFS_CYCLO: rd_word = cyc_i[31:0];
            OFS_CYCHI: rd_word = cyc_i[63:32];
            default: begin
                if (page == PAGE_VALUE) begin
                    if (slot == 5'(CYC_SLOT)) begin
                        rd_word = cyc_i[31:0];
                    end else begin
                        for (int n = 0; n < NUM; n++) begin
                            if (slot == 5'(n)) rd_word = cnt_i[n];
                        end
                    end
                end else if (page == PAGE_TYPE) begin
                    if (slot == 5'(CYC_SLOT)) begin
                        rd_word = {24'd0, CODE_TICK};
                    end else begin
                        for (int n = 0; n < NUM; n++) begin
                            if (slot == 5'(n)) rd_word = {24'd0, type_i[n]};
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd;
            rdata_q  <= rd ? rd_word : '0;
        end
    end

    assign rvalid_o = rvalid_q;
    assign rdata_o  = rdata_q;

    AST_RVALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rvalid_o |-> $past(req_i && !we_i)); // R11
    AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rvalid_o |-> (rdata_o == '0)); // R11

endmodule

// File: rtl/clu_pmu.sv
module clu_pmu
    import clu_pmu_pkg::*;
#(
    parameter int                   NUM_EVT   = 6,
    parameter logic [7:0]           ID_CODE   = 8'h5A,
    parameter logic [7:0]           IMPL_CODE = 8'hC3,
    parameter logic [EVT_CODES-1:0] CODE_MASK = 64'h0000_1E00_6602_0000
)(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 req_i,
    input  logic                 we_i,
    input  logic [7:0]           addr_i,
    input  logic [31:0]          wdata_i,
    input  logic [EVT_CODES-1:0] evt_i,
    output logic                 rvalid_o,
    output logic [31:0]          rdata_o,
    output logic                 irq_o
);

    localparam logic [31:0] LEGAL = ((32'd1 << NUM_EVT) - 32'd1) | (32'd1 << CYC_SLOT);

    port_strobe_t                 stb;
    logic [NUM_EVT-1:0]           cnt_we;
    logic [NUM_EVT-1:0]           type_we;
    logic [NUM_EVT-1:0][CNT_W-1:0] cnt_val;
    logic [NUM_EVT-1:0][7:0]      type_val;
    logic [NUM_EVT-1:0]           ev_wrap;
    logic [CYC_W-1:0]             cyc_val;
    logic                         cyc_wrap;
    logic [31:0]                  wrap_vec;
    logic                         clr_ev;
    logic                         clr_cyc;

    logic                         run_q;
    logic [31:0]                  en_q;
    logic [31:0]                  ie_q;
    logic [31:0]                  ovf_q;

    assign clr_ev  = stb.ctrl & wdata_i[1];
    assign clr_cyc = stb.ctrl & wdata_i[2];

    clu_pmu_regport #(
        .NUM       (NUM_EVT),
        .ID_CODE   (ID_CODE),
        .IMPL_CODE (IMPL_CODE),
        .CODE_MASK (CODE_MASK)
    ) u_port (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (req_i),
        .we_i      (we_i),
        .addr_i    (addr_i),
        .run_i     (run_q),
        .en_i      (en_q),
        .ie_i      (ie_q),
        .ovf_i     (ovf_q),
        .cyc_i     (cyc_val),
        .cnt_i     (cnt_val),
        .type_i    (type_val),
        .stb_o     (stb),
        .cnt_we_o  (cnt_we),
        .type_we_o (type_we),
        .rvalid_o  (rvalid_o),
        .rdata_o   (rdata_o)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        logic link;
        if (g % 2 == 1) begin : g_odd
            assign link = ev_wrap[g-1];
        end else begin : g_even
            assign link = 1'b0;
        end

        clu_pmu_evcnt #(
            .IDX       (g),
            .CODE_MASK (CODE_MASK)
        ) u_cnt (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .count_en_i   (run_q & en_q[g]),
            .clr_i        (clr_ev),
            .val_we_i     (cnt_we[g]),
            .val_wdata_i  (wdata_i),
            .type_we_i    (type_we[g]),
            .type_wdata_i (wdata_i[7:0]),
            .evt_i        (evt_i),
            .link_i       (link),
            .value_o      (cnt_val[g]),
            .type_o       (type_val[g]),
            .wrap_o       (ev_wrap[g])
        );
    end

    clu_pmu_cyccnt u_cyc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .count_en_i (run_q & en_q[CYC_SLOT]),
        .clr_i      (clr_cyc),
        .lo_we_i    (stb.cyc_lo),
        .hi_we_i    (stb.cyc_hi),
        .wdata_i    (wdata_i),
        .value_o    (cyc_val),
        .wrap_o     (cyc_wrap)
    );

    always_comb begin
        wrap_vec                = '0;
        wrap_vec[NUM_EVT-1:0]   = ev_wrap;
        wrap_vec[CYC_SLOT]      = cyc_wrap;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= 1'b0;
            en_q  <= '0;
            ie_q  <= '0;
            ovf_q <= '0;
        end else begin
            if (stb.ctrl) run_q <= wdata_i[0];
            if (stb.en)   en_q  <= wdata_i & LEGAL;
            if (stb.ie)   ie_q  <= wdata_i & LEGAL;
            ovf_q <= stb.ovf_rd ? wrap_vec : (ovf_q | wrap_vec);
        end
    end

    assign irq_o = |(ovf_q & ie_q);

    AST_OVF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stb.ovf_rd |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R6
    AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb.ovf_rd |=> ((ovf_q & ~$past(wrap_vec)) == '0)); // R6
    AST_MASK_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((en_q | ie_q | ovf_q) & ~LEGAL) == '0); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ie_q == '0) |-> !irq_o); // R7

endmodule

// File: tb/sim_clu_pmu.sv
`timescale 1ns/1ps
module sim_clu_pmu;

    localparam int          NUM  = 6;
    localparam logic [7:0]  IDC  = 8'h5A;
    localparam logic [7:0]  IMC  = 8'hC3;
    localparam logic [63:0] MASK = 64'h0000_1E00_6602_0000;
    localparam logic [31:0] LEG  = 32'h8000_003F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [63:0] evt = '0;
    logic        rvalid;
    logic [31:0] rdata;
    logic        irq;

    always #2 clk = ~clk;

    clu_pmu #(.NUM_EVT(NUM), .ID_CODE(IDC), .IMPL_CODE(IMC), .CODE_MASK(MASK)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .evt_i(evt), .rvalid_o(rvalid), .rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference state
    logic [31:0] m_cnt [32];
    logic [7:0]  m_typ [32];
    logic [63:0] m_cyc;
    logic        m_run;
    logic [31:0] m_en, m_ie, m_ovf;
    logic        exp_rv;
    logic [31:0] exp_rd;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    fin = 0;
    string tag = "R1";

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int s = int'(a[4:0]);
        case (a)
            8'h00: return {IMC, IDC, 5'(NUM), 10'd0, m_run};
            8'h01: return m_en;
            8'h02: return m_ie;
            8'h03: return m_ovf;
            8'h04: return MASK[31:0];
            8'h05: return MASK[63:32];
            8'h06: return m_cyc[31:0];
            8'h07: return m_cyc[63:32];
            default: ;
        endcase
        if (a[7:5] == 3'b010) return (s == 31) ? m_cyc[31:0] : ((s < NUM) ? m_cnt[s] : 32'd0);
        if (a[7:5] == 3'b011) return (s == 31) ? 32'h11 : ((s < NUM) ? {24'd0, m_typ[s]} : 32'd0);
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        logic        wr_c, rd_c, clr_e, clr_c, lo_w, hi_w, hit, inc;
        logic [31:0] wrv;
        logic [31:0] nxt [32];
        if (!rst_n) begin
            for (int n = 0; n < 32; n++) begin m_cnt[n] = '0; m_typ[n] = '0; end
            m_cyc = '0; m_run = 0; m_en = '0; m_ie = '0; m_ovf = '0;
            exp_rv = 0; exp_rd = '0;
        end else begin
            wr_c   = req && we;
            rd_c   = req && !we;
            exp_rv = rd_c;
            exp_rd = rd_c ? m_read(addr) : 32'd0;
            clr_e  = wr_c && addr == 8'h00 && wdata[1];
            clr_c  = wr_c && addr == 8'h00 && wdata[2];
            lo_w   = wr_c && (addr == 8'h06 || addr == 8'h5F);
            hi_w   = wr_c && addr == 8'h07;
            wrv    = '0;
            for (int n = 0; n < NUM; n++) begin
                logic pre;
                pre = wr_c && (int'(addr) == 64 + n);
                if (m_typ[n] == 8'h11) hit = 1;
                else if (m_typ[n] == 8'h1e) hit = (n % 2 == 1) && wrv[(n + 31) % 32];
                else if (m_typ[n] < 8'd64) hit = MASK[m_typ[n][5:0]] && evt[m_typ[n][5:0]];
                else hit = 0;
                inc = m_run && m_en[n] && hit && !clr_e && !pre;
                if (inc && m_cnt[n] == 32'hFFFF_FFFF) wrv[n] = 1;
                nxt[n] = clr_e ? 32'd0 : pre ? wdata : inc ? m_cnt[n] + 1 : m_cnt[n];
            end
            inc = m_run && m_en[31] && !clr_c && !lo_w && !hi_w;
            if (inc && m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) wrv[31] = 1;
            if (clr_c) m_cyc = '0;
            else begin
                if (lo_w) m_cyc[31:0] = wdata;
                if (hi_w) m_cyc[63:32] = wdata;
                if (inc) m_cyc = m_cyc + 1;
            end
            for (int n = 0; n < NUM; n++) m_cnt[n] = nxt[n];
            m_ovf = (rd_c && addr == 8'h03) ? wrv : (m_ovf | wrv);
            if (wr_c) begin
                if (addr == 8'h00) m_run = wdata[0];
                if (addr == 8'h01) m_en = wdata & LEG;
                if (addr == 8'h02) m_ie = wdata & LEG;
                for (int n = 0; n < NUM; n++)
                    if (int'(addr) == 96 + n) m_typ[n] = wdata[7:0];
            end
        end
    end

    // compare every clock, away from the active edge (R11 read path, R7 interrupt)
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            n_cmp++;
            if (rvalid !== exp_rv || rdata !== exp_rd) begin
                n_bad++;
                $display("FAIL %s (R11 read port): got valid=%b data=%h expected valid=%b data=%h",
                         tag, rvalid, rdata, exp_rv, exp_rd);
            end
            n_cmp++;
            if (irq !== |(m_ovf & m_ie)) begin
                n_bad++;
                $display("FAIL R7 (%s) irq: got %b expected %b", tag, irq, |(m_ovf & m_ie));
            end
        end
    end

    always @(negedge clk) evt <= {$urandom, $urandom};

    task automatic put(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    endtask

    task automatic get(input logic [7:0] a);
        @(negedge clk); req = 1; we = 0; addr = a; wdata = '0;
    endtask

    task automatic rest(input int n);
        @(negedge clk); req = 0; we = 0; addr = '0; wdata = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        fin = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (%s): run did not end, got running expected done", tag);
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        rest(2);

        tag = "R1";  // reset state and identification fields
        get(8'h00); get(8'h01); get(8'h03); get(8'h06);
        put(8'h00, 32'hFFFF_FFF8); get(8'h00);
        put(8'h00, 32'h0); get(8'h00);
        rest(2);

        tag = "R3";  // event ID pair and event sources
        get(8'h04); get(8'h05);
        put(8'h60, 32'h19); put(8'h61, 32'h11); put(8'h62, 32'h05);
        put(8'h63, 32'h2b); put(8'h64, 32'h7a); put(8'h65, 32'hFFFF_FF1a);
        for (int k = 0; k < 6; k++) get(8'(96 + k));
        put(8'h7F, 32'h22); get(8'h7F);

        tag = "R2";  // gated counting
        put(8'h01, 32'h0000_003F);
        repeat (10) get(8'h41);
        put(8'h00, 32'h1);
        rest(30);
        for (int k = 0; k < 6; k++) get(8'(64 + k));
        put(8'h01, 32'h0000_0005);
        rest(12);
        for (int k = 0; k < 6; k++) get(8'(64 + k));
        put(8'h00, 32'h0);
        rest(8);
        for (int k = 0; k < 6; k++) get(8'(64 + k));

        tag = "R4";  // chained pair and even link
        put(8'h62, 32'h11); put(8'h42, 32'hFFFF_FFFA);
        put(8'h63, 32'h1e); put(8'h43, 32'h7);
        put(8'h64, 32'h1e); put(8'h44, 32'h100);
        put(8'h01, 32'h0000_001C); put(8'h00, 32'h1);
        for (int k = 0; k < 12; k++) begin get(8'h42); get(8'h43); get(8'h44); end

        tag = "R6";  // read-to-clear overflow, wrap during the read
        put(8'h02, 32'h0000_000C);
        rest(2);
        get(8'h03); get(8'h03);
        put(8'h60, 32'h11); put(8'h40, 32'hFFFF_FFF4); put(8'h01, 32'h0000_0001);
        repeat (20) get(8'h03);
        put(8'h03, 32'hFFFF_FFFF); get(8'h03);

        tag = "R7";  // interrupt masking
        put(8'h40, 32'hFFFF_FFFE); put(8'h02, 32'h0);
        rest(6);
        put(8'h02, 32'h0000_0001);
        rest(3);
        get(8'h03);
        rest(3);

        tag = "R5";  // 64-bit cycle counter and its alias
        put(8'h01, 32'h8000_0000);
        put(8'h07, 32'hFFFF_FFFF); put(8'h5F, 32'hFFFF_FFF6);
        put(8'h02, 32'h8000_0000);
        for (int k = 0; k < 10; k++) begin get(8'h06); get(8'h07); end
        get(8'h5F); get(8'h03); get(8'h07);
        put(8'h06, 32'h1234_5678); get(8'h5F);

        tag = "R8";  // reset commands
        put(8'h01, 32'h8000_003F);
        rest(10);
        put(8'h00, 32'h3); get(8'h40); get(8'h41); get(8'h06);
        rest(5);
        put(8'h00, 32'h5); get(8'h06); get(8'h07); get(8'h41);
        put(8'h41, 32'h55); put(8'h00, 32'h3); get(8'h41);

        tag = "R9";  // preload beats increment
        for (int k = 0; k < 5; k++) begin put(8'h41, 32'h1000 + k); get(8'h41); end
        put(8'h06, 32'hABCD_0000); get(8'h06);

        tag = "R10"; // unimplemented slots
        put(8'h47, 32'hDEAD_BEEF); get(8'h47);
        put(8'h5E, 32'h1); get(8'h5E);
        put(8'h67, 32'h11); get(8'h67);
        put(8'h01, 32'hFFFF_FFFF); get(8'h01);
        put(8'h02, 32'hFFFF_FFC0); get(8'h02);
        rest(4);

        tag = "R11"; // response timing and idle data
        get(8'h00); rest(3); get(8'h04); put(8'h01, 32'h0); get(8'h01); get(8'h01);
        rest(4);

        summary();
    end

endmodule